// File: doc/BRIEF.md
# Reset Strap Capture and DRAM Strobe Mapper

This block sits between the internal memory sequencer of a display controller and the pins of its video DRAM. While the host holds reset, the block keeps its own drivers off the 16-bit memory data bus. This lets external pull resistors present configuration straps on that bus. When reset is released, the block records a four-bit auxiliary configuration value and a two-bit hardware option field from the bus.

After reset the block turns the sequencer's active-high requests into active-low DRAM strobes: row strobe, column strobe, write enable and per-byte selects. It places them on a dedicated row strobe pin and three shared pins named A, B and C. Option bit 1, which is taken from data bit 6, picks how the shared pins are used. When it is 0, the DRAM has two column strobes and one write enable. When it is 1, the DRAM has one column strobe and two write enables.

A hardware suspend flag makes the block ignore the reset input entirely. All strobe and data-bus handshakes are plain level signals. There is no flow control.

Top module: `strap_strobe_map`

## Requirements
- R1: While reset is applied (rst_in=1 and suspend=0), and in the first cycle after it is released, md_oe is 0 and the block does not drive md, whatever md_drive_req is.
- R2: At all other times md_oe equals md_drive_req with no clock delay, and md carries md_dout whenever md_oe is 1.
- R3: At the first rising clock edge where rst_in is sampled 0 after being sampled 1 (suspend=0 at both edges), aux_cfg takes the value of md[3:0], visible right after that edge.
- R4: At that same edge hw_opt takes md[6:5]. hw_opt[1] (data bit 6) is the pin mapping: 0 selects dual-CAS, 1 selects dual-WE.
- R5: While reset is applied, aux_cfg and hw_opt read 0.
- R6: Dual-CAS mapping: pin_a is low when cas_req and byte_en[0] are both high. pin_b is low when cas_req and byte_en[1] are both high. pin_c is low when we_req is high.
- R7: Dual-WE mapping: pin_a is low when we_req and byte_en[0] are both high. pin_b is low when cas_req is high, for any byte selection. pin_c is low when we_req and byte_en[1] are both high.
- R8: ras_n is low when ras_req is high, in both mappings.
- R9: All four strobe pins are registered. Each one reflects the requests sampled at the previous rising edge. All of them are held high after any edge at which reset was applied, and after the first edge following its release.
- R10: While suspend=1, rst_in has no effect. Straps are not cleared or recaptured, strobes keep following their requests, and md_oe keeps following md_drive_req.
- R11: aux_cfg and hw_opt keep their values until the next reset that is applied outside suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_in | input | 1 | Host reset, active high |
| suspend | input | 1 | Hardware suspend; while high, rst_in is ignored |
| md | inout | 16 | Video memory data bus |
| md_dout | input | 16 | Data to drive onto md |
| md_drive_req | input | 1 | Request to drive md |
| ras_req | input | 1 | Row strobe request |
| cas_req | input | 1 | Column strobe request |
| we_req | input | 1 | Write request |
| byte_en | input | 2 | Byte selects: bit 0 low byte, bit 1 high byte |
| ras_n | output | 1 | Row strobe pin, active low |
| pin_a | output | 1 | Shared strobe pin A, active low |
| pin_b | output | 1 | Shared strobe pin B, active low |
| pin_c | output | 1 | Shared strobe pin C, active low |
| md_oe | output | 1 | Data bus output enable |
| aux_cfg | output | 4 | Captured configuration bits 3:0 |
| hw_opt | output | 2 | Captured option bits 6:5 |

## Verification
The hardest situation to reach is reset asserted while suspend is high. Here the block must ignore the reset completely, and a wrong design would lose or recapture its straps. The stimulus first captures one strap pattern and raises suspend. It then holds rst_in high while presenting a second pattern and keeps issuing strobe and bus requests. Finally it drops rst_in before suspend, so that a falling edge is seen while suspended. The release cycle is also covered, in which strobes and drivers stay off although requests are active. The stimulus reaches it by keeping requests high through the release of reset.

// File: rtl/strap_map_pkg.sv
package strap_map_pkg;
  localparam int DATA_W  = 16;
  localparam int AUX_W   = 4;
  localparam int OPT_LSB = 5;
  localparam int OPT_W   = 2;
  localparam int BYTES   = 2;

  typedef enum logic {
    MAP_DUAL_CAS = 1'b0,
    MAP_DUAL_WE  = 1'b1
  } map_mode_e;
endpackage

// File: rtl/strap_capture.sv
module strap_capture
  import strap_map_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int AW  = AUX_W,
  parameter int OL  = OPT_LSB,
  parameter int OW  = OPT_W
) (
  input  logic          clk,
  input  logic          rst_in,
  input  logic          suspend,
  input  logic [DW-1:0] md_in,
  output logic          rst_eff,
  output logic          rel_cycle,
  output logic [AW-1:0] aux_cfg,
  output logic [OW-1:0] hw_opt
);
  logic rst_seen_q;

  // Reset is qualified by suspend before anything else sees it.
  assign rst_eff   = rst_in & ~suspend;
  assign rel_cycle = rst_seen_q;

  always_ff @(posedge clk) begin
    rst_seen_q <= rst_eff;
    if (rst_eff) begin
      aux_cfg <= '0;
      hw_opt  <= '0;
    end else if (rst_seen_q) begin
      aux_cfg <= md_in[AW-1:0];
      hw_opt  <= md_in[OL+OW-1:OL];
    end
  end

  assert_clear_in_reset_R5: assert property (@(posedge clk)
    rst_eff |=> (aux_cfg == '0 && hw_opt == '0));

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst_eff)
    (!rst_eff && !rst_seen_q) |=> ($stable(aux_cfg) && $stable(hw_opt)));

  assert_suspend_ignored_R10: assert property (@(posedge clk) disable iff (rst_eff)
    (suspend && !rst_seen_q) |=> ($stable(aux_cfg) && $stable(hw_opt)));
endmodule

// File: rtl/strobe_mapper.sv
module strobe_mapper
  import strap_map_pkg::*;
#(
  parameter int NB = BYTES
) (
  input  logic          clk,
  input  logic          block,
  input  map_mode_e     mode,
  input  logic          ras_req,
  input  logic          cas_req,
  input  logic          we_req,
  input  logic [NB-1:0] byte_en,
  output logic          ras_n,
  output logic          pin_a,
  output logic          pin_b,
  output logic          pin_c
);
  logic [NB-1:0] cas_lane;
  logic [NB-1:0] we_lane;
  logic          a_d, b_d, c_d;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign cas_lane[i] = cas_req & byte_en[i];
    assign we_lane[i]  = we_req  & byte_en[i];
  end

  always_comb begin
    if (mode == MAP_DUAL_WE) begin
      a_d = ~we_lane[0];
      b_d = ~cas_req;
      c_d = ~we_lane[NB-1];
    end else begin
      a_d = ~cas_lane[0];
      b_d = ~cas_lane[NB-1];
      c_d = ~we_req;
    end
  end

  always_ff @(posedge clk) begin
    if (block) begin
      ras_n <= 1'b1;
      pin_a <= 1'b1;
      pin_b <= 1'b1;
      pin_c <= 1'b1;
    end else begin
      ras_n <= ~ras_req;
      pin_a <= a_d;
      pin_b <= b_d;
      pin_c <= c_d;
    end
  end

  assert_idle_when_blocked_R9: assert property (@(posedge clk)
    block |=> (ras_n && pin_a && pin_b && pin_c));

  assert_single_cas_R7: assert property (@(posedge clk) disable iff (block)
    (mode == MAP_DUAL_WE && cas_req) |=> !pin_b);

  assert_single_we_R6: assert property (@(posedge clk) disable iff (block)
    (mode == MAP_DUAL_CAS && we_req) |=> !pin_c);
endmodule

// File: rtl/md_bus_ctl.sv
module md_bus_ctl (
  input  logic rst_eff,
  input  logic rel_cycle,
  input  logic drive_req,
  output logic md_oe
);
  // Drivers stay off through reset and the strap sampling cycle.
  assign md_oe = drive_req & ~rst_eff & ~rel_cycle;
endmodule

// File: rtl/strap_strobe_map.sv
module strap_strobe_map
  import strap_map_pkg::*;
(
  input  logic              clk,
  input  logic              rst_in,
  input  logic              suspend,
  inout  wire  [DATA_W-1:0] md,
  input  logic [DATA_W-1:0] md_dout,
  input  logic              md_drive_req,
  input  logic              ras_req,
  input  logic              cas_req,
  input  logic              we_req,
  input  logic [BYTES-1:0]  byte_en,
  output logic              ras_n,
  output logic              pin_a,
  output logic              pin_b,
  output logic              pin_c,
  output logic              md_oe,
  output logic [AUX_W-1:0]  aux_cfg,
  output logic [OPT_W-1:0]  hw_opt
);
  logic      rst_eff;
  logic      rel_cycle;
  map_mode_e mode;

  assign md   = md_oe ? md_dout : 'z;
  assign mode = map_mode_e'(hw_opt[OPT_W-1]);

  strap_capture u_cap (
    .clk       (clk),
    .rst_in    (rst_in),
    .suspend   (suspend),
    .md_in     (md),
    .rst_eff   (rst_eff),
    .rel_cycle (rel_cycle),
    .aux_cfg   (aux_cfg),
    .hw_opt    (hw_opt)
  );

  md_bus_ctl u_bus (
    .rst_eff   (rst_eff),
    .rel_cycle (rel_cycle),
    .drive_req (md_drive_req),
    .md_oe     (md_oe)
  );

  strobe_mapper u_map (
    .clk     (clk),
    .block   (rst_eff | rel_cycle),
    .mode    (mode),
    .ras_req (ras_req),
    .cas_req (cas_req),
    .we_req  (we_req),
    .byte_en (byte_en),
    .ras_n   (ras_n),
    .pin_a   (pin_a),
    .pin_b   (pin_b),
    .pin_c   (pin_c)
  );

  assert_bus_off_in_reset_R1: assert property (@(posedge clk)
    rst_in && !suspend |-> !md_oe);
endmodule

// File: tb/strap_strobe_map_tb.sv
module strap_strobe_map_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_in, suspend, md_drive_req, ras_req, cas_req, we_req;
  logic [15:0] md_dout, tb_md;
  logic        tb_md_en;
  logic [1:0]  byte_en;
  wire  [15:0] md;
  logic        ras_n, pin_a, pin_b, pin_c, md_oe;
  logic [3:0]  aux_cfg;
  logic [1:0]  hw_opt;

  int checks = 0, failures = 0;
  bit model_live = 0;

  // reference model state
  bit       m_inq = 0;
  bit [3:0] m_aux = 0;
  bit [1:0] m_opt = 0;
  bit       m_ras = 1, m_a = 1, m_b = 1, m_c = 1;

  assign md = tb_md_en ? tb_md : 'z;

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_strobe_map u_dut (
    .clk(clk), .rst_in(rst_in), .suspend(suspend), .md(md),
    .md_dout(md_dout), .md_drive_req(md_drive_req),
    .ras_req(ras_req), .cas_req(cas_req), .we_req(we_req), .byte_en(byte_en),
    .ras_n(ras_n), .pin_a(pin_a), .pin_b(pin_b), .pin_c(pin_c),
    .md_oe(md_oe), .aux_cfg(aux_cfg), .hw_opt(hw_opt)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural model, advanced at each rising edge
  always @(posedge clk) begin
    bit reff;
    bit wr0, wr1;
    reff = rst_in && !suspend;
    wr0 = we_req && byte_en[0];
    wr1 = we_req && byte_en[1];
    if (reff || m_inq) begin
      m_ras = 1; m_a = 1; m_b = 1; m_c = 1;
    end else begin
      m_ras = !ras_req;
      if (m_opt[1]) begin
        m_a = !wr0; m_b = !cas_req; m_c = !wr1;
      end else begin
        m_a = !(cas_req && byte_en[0]);
        m_b = !(cas_req && byte_en[1]);
        m_c = !we_req;
      end
    end
    if (reff) begin
      m_aux = 0; m_opt = 0;
    end else if (m_inq) begin
      m_aux = md[3:0]; m_opt = md[6:5];
    end
    m_inq = reff;
    model_live = 1;
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    bit e_oe;
    if (model_live) begin
      e_oe = md_drive_req && !(rst_in && !suspend) && !m_inq;
      check(md_oe == e_oe, "R1/R2 md_oe", md_oe, e_oe);
      if (e_oe) check(md == md_dout, "R2 md", md, md_dout);
      check(aux_cfg == m_aux, "R3/R5/R11 aux_cfg", aux_cfg, m_aux);
      check(hw_opt == m_opt, "R4/R5/R11 hw_opt", hw_opt, m_opt);
      check(ras_n == m_ras, "R8/R9 ras_n", ras_n, m_ras);
      check(pin_a == m_a, "R6/R7/R9 pin_a", pin_a, m_a);
      check(pin_b == m_b, "R6/R7/R9 pin_b", pin_b, m_b);
      check(pin_c == m_c, "R6/R7/R9 pin_c", pin_c, m_c);
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic req(input bit r, input bit c, input bit w, input bit [1:0] be);
    ras_req = r; cas_req = c; we_req = w; byte_en = be;
  endtask

  // reset with strap pattern, requests kept active through release
  task automatic do_reset(input logic [15:0] strap);
    rst_in = 1; tb_md_en = 1; tb_md = strap; md_drive_req = 1;
    req(1, 1, 1, 2'b11);
    step(1);
    check(md_oe == 0, "R1 oe low in reset", md_oe, 0);
    check(aux_cfg == 0 && hw_opt == 0, "R5 cleared in reset", {hw_opt, aux_cfg}, 0);
    step(2);
    rst_in = 0; md_drive_req = 0;
    step(1);
    // capture edge just passed; strobes still idle
    check(aux_cfg == strap[3:0], "R3 aux capture", aux_cfg, strap[3:0]);
    check(hw_opt == strap[6:5], "R4 opt capture", hw_opt, strap[6:5]);
    check(pin_a && pin_b && pin_c && ras_n, "R9 idle in release cycle",
          {ras_n, pin_a, pin_b, pin_c}, 4'hf);
    tb_md_en = 0;
    step(1);
    check(ras_n == 0 && pin_b == 0, "R9 strobes resume", {ras_n, pin_b}, 0);
  endtask

  task automatic sweep(input int n);
    for (int i = 0; i < n; i++) begin
      req($urandom % 2, $urandom % 2, $urandom % 2, 2'($urandom));
      md_drive_req = $urandom % 2;
      md_dout = 16'($urandom);
      step(1);
    end
  endtask

  initial begin
    rst_in = 1; suspend = 0; tb_md_en = 1; tb_md = 0; md_dout = 16'h1234;
    md_drive_req = 0; req(0, 0, 0, 0);
    step(1);

    // dual-CAS: bit6=0, bit5=1, aux=5
    do_reset(16'h0025);
    req(0, 1, 0, 2'b01); step(1);
    check(pin_a == 0 && pin_b == 1 && pin_c == 1, "R6 low byte read",
          {pin_a, pin_b, pin_c}, 3'b011);
    req(1, 1, 1, 2'b10); step(1);
    check(pin_a == 1 && pin_b == 0 && pin_c == 0, "R6 high byte write",
          {pin_a, pin_b, pin_c}, 3'b100);
    check(ras_n == 0, "R8 ras", ras_n, 0);
    md_drive_req = 1; md_dout = 16'hBEEF; step(1);
    check(md_oe == 1 && md == 16'hBEEF, "R2 drive", md, 16'hBEEF);
    sweep(40);

    // suspend: reset ignored
    md_drive_req = 1; suspend = 1; step(1);
    rst_in = 1; req(0, 0, 1, 2'b11); step(3);
    check(md_oe == 1, "R10 oe under suspend", md_oe, 1);
    check(pin_c == 0, "R10 strobes under suspend", pin_c, 0);
    rst_in = 0; step(2);
    check(aux_cfg == 4'h5 && hw_opt == 2'b01, "R10 straps kept",
          {hw_opt, aux_cfg}, 6'h15);
    sweep(10);
    suspend = 0;
    sweep(20);
    check(aux_cfg == 4'h5, "R11 hold", aux_cfg, 5);

    // dual-WE: bit6=1, bit5=0, aux=A
    do_reset(16'h004A);
    req(0, 1, 0, 2'b00); step(1);
    check(pin_a && !pin_b && pin_c, "R7 single cas no bytes",
          {pin_a, pin_b, pin_c}, 3'b101);
    req(0, 1, 1, 2'b01); step(1);
    check(!pin_a && !pin_b && pin_c, "R7 low byte write",
          {pin_a, pin_b, pin_c}, 3'b001);
    req(0, 0, 1, 2'b10); step(1);
    check(pin_a && pin_b && !pin_c, "R7 high byte write",
          {pin_a, pin_b, pin_c}, 3'b110);
    sweep(60);
    check(hw_opt == 2'b10, "R11 mode held", hw_opt, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule